// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Output Control

This block is one bank of general-purpose pins behind a 32-bit register slave port. Software picks the direction of each pin, drives output levels through an output latch, and reads back the pin levels after they have been resynchronized to the block clock. The latch can be written whole. It can also be changed one bit at a time through a write-one-to-set word and a write-one-to-clear word, so no read-modify-write sequence is needed. When several agents share one bank, none of them can overwrite another's bits.

The register port takes a word address, a write strobe and write data. Read data is combinational from the word address. A direction bit of 1 makes the pin an input. A direction bit of 0 makes it an output and turns on its output enable. The input word always reports the synchronized pin level, including on pins that drive. A read that follows an output change too closely can therefore still show the old level. Interrupt edge selection and status belong to a separate block. Their word addresses read as zero here and writes to them are ignored.

Top module: `gpio_sc_bank`

## Requirements
- R1: After reset every direction bit is 1 (input). The output latch, `pin_out`, `pin_oe` and the input word are all 0.
- R2: A write to word 0 (direction) loads it, and the word reads back the value written. From the next clock edge, `pin_oe[i]` is the inverse of direction bit i.
- R3: A write to word 1 (output data) loads the whole latch. Word 1 reads the latch, and `pin_out` shows the new value after that clock edge.
- R4: A write to word 2 (set) forces to 1 every latch bit where the write data has a 1. All other bits keep their value.
- R5: A write to word 3 (clear) forces to 0 every latch bit where the write data has a 1. All other bits keep their value.
- R6: Reads of word 2 and word 3 return the current output latch.
- R7: Word 4 (input data) reports `pin_in` through two synchronizing flops. A pin change first shows after the second rising edge, and still shows the old value after only one edge.
- R8: Word 4 reports the sampled `pin_in` level even on pins set as outputs, independently of `pin_out`.
- R9: Writes to word 4 and to unmapped word addresses (5 and above) change no register. Reads of unmapped words return 0.
- R10: The latch and `pin_out` keep their value while the direction changes. They can also be updated while a pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_waddr | input | WADDR_W (4) | Word address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_waddr`, combinational |
| pin_in | input | NPINS (32) | Pin levels seen at the pads, asynchronous |
| pin_out | output | NPINS (32) | Output latch driven to the pads |
| pin_oe | output | NPINS (32) | Output enable per pin, active high |

## Verification
The assertions take it that `reg_we`, `reg_waddr` and `reg_wdata` are synchronous to `clk` and carry at most one write per cycle. The bench keeps to this by driving every register access on the falling edge and releasing the strobe one cycle later. The synchronizer check relies only on `pin_in` being sampled at rising edges. The bench changes `pin_in` on falling edges and holds it for at least two cycles before it expects the new level on word 4. Unmapped-word writes use all-ones data, so a decode slip would show on every bit.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   // word indices of the bank; byte offset is four times the index
   typedef enum logic [2:0] {
      GW_DIR = 3'd0,
      GW_OUT = 3'd1,
      GW_SET = 3'd2,
      GW_CLR = 3'd3,
      GW_IN  = 3'd4,
      GW_NONE = 3'd7
   } gpio_word_e;

   localparam int unsigned GPIO_MAPPED_WORDS = 5;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int unsigned WADDR_W = 4
) (
   input  logic [WADDR_W-1:0] waddr,
   input  logic               we,
   output gpio_word_e         rsel,
   output logic               wr_dir,
   output logic               wr_out,
   output logic               wr_set,
   output logic               wr_clr
);

   localparam int unsigned MAX_WORDS = 1 << WADDR_W;

   if (MAX_WORDS < GPIO_MAPPED_WORDS) begin : g_bad_waddr
      $error("gpio_sc_decode: WADDR_W too small for the bank map");
   end

   always_comb begin
      rsel = GW_NONE;
      if (int'(waddr) < GPIO_MAPPED_WORDS) begin
         rsel = gpio_word_e'(waddr[2:0]);
      end
   end

   // word 4 is read-only; unmapped words decode to nothing
   assign wr_dir = we && (rsel == GW_DIR);
   assign wr_out = we && (rsel == GW_OUT);
   assign wr_set = we && (rsel == GW_SET);
   assign wr_clr = we && (rsel == GW_CLR);

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
         end
      end
   end

   assign q = stage[STAGES-1];

   // edges since reset, saturating; used to window the latency check
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age <= '0;
      else if (age != 2'd3)   age <= age + 2'd1;
   end

   if (STAGES == 2) begin : g_chk2
      p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 2'd2) |-> (q == $past(d, 2)));
   end

endmodule

// File: rtl/gpio_sc_latch.sv
module gpio_sc_latch #(
   parameter int unsigned       WIDTH    = 32,
   parameter logic [WIDTH-1:0]  RST_VAL  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] q_nxt;

   // load first, then set, then clear: clear wins on a shared bit
   always_comb begin
      q_nxt = load ? load_val : q;
      q_nxt = q_nxt | set_mask;
      q_nxt = q_nxt & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= q_nxt;
   end

   p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && clr_mask == '0 && set_mask != '0)
      |=> ((q & $past(set_mask)) == $past(set_mask)));

   p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |=> ((q & $past(clr_mask)) == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && set_mask == '0 && clr_mask == '0) |=> $stable(q));

endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
   import gpio_sc_pkg::*;
#(
   parameter int unsigned NPINS   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WADDR_W = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WADDR_W-1:0] reg_waddr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe
);

   localparam logic [NPINS-1:0] DIR_RST = '1;

   if (NPINS == 0 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_sc_bank: NPINS must be 1..DATA_W");
   end

   gpio_word_e       rsel;
   logic             wr_dir, wr_out, wr_set, wr_clr;
   logic [NPINS-1:0] dir_q, out_q, in_q;
   logic [NPINS-1:0] wpins;

   assign wpins = reg_wdata[NPINS-1:0];

   gpio_sc_decode #(.WADDR_W(WADDR_W)) i_decode (
      .waddr  (reg_waddr),
      .we     (reg_we),
      .rsel   (rsel),
      .wr_dir (wr_dir),
      .wr_out (wr_out),
      .wr_set (wr_set),
      .wr_clr (wr_clr)
   );

   // direction: plain loadable register, inputs after reset
   gpio_sc_latch #(.WIDTH(NPINS), .RST_VAL(DIR_RST)) i_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_dir),
      .load_val (wpins),
      .set_mask ('0),
      .clr_mask ('0),
      .q        (dir_q)
   );

   gpio_sc_latch #(.WIDTH(NPINS), .RST_VAL('0)) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_out),
      .load_val (wpins),
      .set_mask (wr_set ? wpins : '0),
      .clr_mask (wr_clr ? wpins : '0),
      .q        (out_q)
   );

   gpio_sc_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_q)
   );

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;

   function automatic logic [DATA_W-1:0] widen(input logic [NPINS-1:0] v);
      logic [DATA_W-1:0] r;
      r = '0;
      r[NPINS-1:0] = v;
      return r;
   endfunction

   always_comb begin
      unique case (rsel)
         GW_DIR:                 reg_rdata = widen(dir_q);
         GW_OUT, GW_SET, GW_CLR: reg_rdata = widen(out_q);
         GW_IN:                  reg_rdata = widen(in_q);
         default:                reg_rdata = '0;
      endcase
   end

   p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_waddr == WADDR_W'(0))
      |=> (pin_oe == ~$past(reg_wdata[NPINS-1:0])));

   p_out_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_waddr == WADDR_W'(1))
      |=> (pin_out == $past(reg_wdata[NPINS-1:0])));

   p_ro_words_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_waddr) >= 4)
      |=> ($stable(pin_out) && $stable(pin_oe)));

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_waddr) >= GPIO_MAPPED_WORDS) |-> (reg_rdata == '0));

endmodule

// File: tb/test_gpio_sc_bank.sv
module test_gpio_sc_bank;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NP = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_waddr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_sc_bank #(.NPINS(NP), .DATA_W(DW), .WADDR_W(AW)) i_gpio_sc_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_waddr (reg_waddr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_waddr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_waddr = a; reg_we = 1'b0;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   // vector: {we, waddr, data, expected read}
   typedef struct packed {
      logic        we;
      logic [3:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd1, 32'hF0F0_F0F0, 32'h0},          // R3 load
      '{1'b0, 4'd1, 32'h0, 32'hF0F0_F0F0},          // R3 readback
      '{1'b1, 4'd2, 32'h0000_00FF, 32'h0},          // R4 set
      '{1'b0, 4'd1, 32'h0, 32'hF0F0_F0FF},          // R4 result
      '{1'b1, 4'd3, 32'hF000_000F, 32'h0},          // R5 clear
      '{1'b0, 4'd2, 32'h0, 32'h00F0_F0F0},          // R5 result, R6 via set word
      '{1'b0, 4'd3, 32'h0, 32'h00F0_F0F0},          // R6 via clear word
      '{1'b1, 4'd0, 32'h0000_FFFF, 32'h0},          // R2 direction
      '{1'b0, 4'd0, 32'h0, 32'h0000_FFFF},          // R2 readback
      '{1'b0, 4'd1, 32'h0, 32'h00F0_F0F0},          // R10 latch kept over dir change
      '{1'b1, 4'd4, 32'h1234_5678, 32'h0},          // R9 write to input word
      '{1'b0, 4'd1, 32'h0, 32'h00F0_F0F0},          // R9 latch untouched
      '{1'b0, 4'd5, 32'h0, 32'h0},                  // R9 unmapped read
      '{1'b1, 4'd9, 32'hFFFF_FFFF, 32'h0},          // R9 unmapped write
      '{1'b0, 4'd0, 32'h0, 32'h0000_FFFF}           // R9 direction untouched
   };

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held and after release
      check("R1 pin_oe", pin_oe, 32'h0);
      check("R1 pin_out", pin_out, 32'h0);
      rst_n = 1'b1;
      rd("R1 dir", 4'd0, 32'hFFFF_FFFF);
      rd("R1 out", 4'd1, 32'h0);
      rd("R1 in", 4'd4, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].we) wr(VEC[i].a, VEC[i].d);
         else rd($sformatf("vec %0d R2-R10 table", i), VEC[i].a, VEC[i].e);
      end

      // R2: output enables follow direction after the edge
      check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
      check("R3 pin_out", pin_out, 32'h00F0_F0F0);

      // R10: latch update while pins are inputs, then switch to outputs
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'h0BAD_CAFE);
      check("R10 pin_out while input", pin_out, 32'h0BAD_CAFE);
      check("R10 pin_oe all input", pin_oe, 32'h0);
      wr(4'd0, 32'h0);
      check("R10 pin_out after dir", pin_out, 32'h0BAD_CAFE);
      check("R2 pin_oe all output", pin_oe, 32'hFFFF_FFFF);

      // R7: two-edge latency from pin_in to input word
      @(negedge clk);
      pin_in = 32'h1357_9BDF;
      rd("R7 one edge old", 4'd4, 32'h0);
      rd("R7 two edges new", 4'd4, 32'h1357_9BDF);

      // R8: input word shows pad level on output pins, not the latch
      @(negedge clk);
      pin_in = 32'hA5A5_A5A5;
      @(negedge clk);
      rd("R8 in on outputs", 4'd4, 32'hA5A5_A5A5);
      check("R8 pin_out kept", pin_out, 32'h0BAD_CAFE);

      // R4/R5 on a single bit at each end
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd2, 32'h8000_0001);
      rd("R4 edge bits", 4'd1, 32'h8000_0001);
      wr(4'd3, 32'h0000_0001);
      rd("R5 low bit", 4'd1, 32'h8000_0000);
      wr(4'd2, 32'h0);
      rd("R4 zero mask", 4'd1, 32'h8000_0000);

      // R1: reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset pin_out", pin_out, 32'h0);
      check("R1 re-reset pin_oe", pin_oe, 32'h0);
      rst_n = 1'b1;
      rd("R1 re-reset dir", 4'd0, 32'hFFFF_FFFF);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule